// File: doc/BRIEF.md
# Oversampled Serial Receiver with Low-Power Freeze

This block receives asynchronous serial characters on a single input line. A 16x oversampling tick paces it. Each character has one start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one stop bit. The received byte goes into a one-entry holding register. Six status flags report the result: buffer full, line idle, overrun, noise, framing error and parity error. Software clears the flags with a two-step read: a status read followed by a data read.

The receiver also takes low-power requests. A stop request always freezes it. A wait request freezes it only when the freeze enable for wait mode is set. While it is frozen, every oversampling tick is ignored and all state is held, including a character that is only partly received. When the request is withdrawn, reception continues from exactly the sample slot where it stopped. A reset taken during a freeze abandons the partial character and returns every register to its reset value.

Top module: `uart_rx_frz`

## Requirements
- R1: A bit lasts 16 accepted ticks. The tick at which the receiver first sees the line low in the idle state is sample 1 of the start bit. The value of a bit is the majority of its samples 8, 9 and 10, and data bits are assembled least significant bit first into `rx_data`.
- R2: If the majority of samples 8, 9 and 10 of a start bit is high, the receiver drops the candidate and goes back to looking for a start bit. No character is delivered.
- R3: If samples 8, 9 and 10 of any bit in a character (start, data, parity or stop) are not all equal, `rx_noise` is set when that character is loaded. A disagreeing sample outside slots 8 to 10 has no effect.
- R4: A stop bit whose majority value is 0 sets `rx_frame_err` when the character is loaded.
- R5: When `parity_en` is 1, a parity bit follows the data. `parity_odd`=0 expects an even count of ones across data and parity, and `parity_odd`=1 expects an odd count. A mismatch sets `rx_parity_err`. When `parity_en` is 0, no parity bit is expected and `rx_parity_err` stays 0.
- R6: A character completes at sample 10 of its stop bit. If `rx_full` is 0, the byte appears on `rx_data` and `rx_full` becomes 1 on the next clock edge.
- R7: If a character completes while `rx_full` is 1, `rx_overrun` is set and `rx_data` and the error flags keep their earlier values.
- R8: After a start bit has been seen, 160 consecutive accepted ticks of a high line in the idle state set `rx_idle`. The flag is raised again only after a new start bit.
- R9: A `rd_data` pulse clears all six flags only if it comes after a `rd_status` pulse that was issued while at least one flag was set. A `rd_data` pulse without that earlier status read changes nothing.
- R10: While `wait_req` and `wait_freeze_en` are both 1, ticks are ignored and a partial character resumes intact afterwards. While `wait_req` is 1 and `wait_freeze_en` is 0, reception runs normally.
- R11: While `stop_req` is 1, ticks are ignored and all state is held. Reception resumes from the same sample slot once `stop_req` is 0.
- R12: `rst_n` low clears `rx_data`, all flags and any partial character, including when it is taken during a freeze.
- R13: While `rx_en` is 0, the receiver stays in the idle state and the line is not sampled, so no character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial input line, high when idle |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| wait_req | input | 1 | Wait-mode request |
| wait_freeze_en | input | 1 | Freeze the receiver in wait mode |
| stop_req | input | 1 | Stop-mode request |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Receive buffer full |
| rx_idle | output | 1 | Idle line detected |
| rx_overrun | output | 1 | Character lost to a full buffer |
| rx_noise | output | 1 | Sample disagreement seen |
| rx_frame_err | output | 1 | Stop bit missing |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
If the slot counter or the bit index is wrong, the received byte comes out shifted, or the framing or parity flag is wrong, as soon as that character completes, which is within eleven bit times. If the counter moves during a freeze, the byte loaded after the wake comes out corrupted, because the bench drives garbage on the line for the whole freeze. If the two-step clear sequence is wrong, the flags either fail to clear or clear too early. The bench sees this at the next check, two clocks after the read pulses.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_gate.sv
module uart_rx_gate (
    input  logic os_tick,
    input  logic rx_en,
    input  logic wait_req,
    input  logic wait_freeze_en,
    input  logic stop_req,
    output logic frozen,
    output logic tick_en
);
    // Freezing only withholds ticks; every register keeps its value.
    always_comb begin
        frozen  = stop_req | (wait_req & wait_freeze_en);
        tick_en = os_tick & rx_en & ~frozen;
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8,
    parameter int IDLE_TICKS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_fe,
    output logic                 frame_pe,
    output logic                 frame_nf,
    output logic                 idle_pulse
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int IDX_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
    localparam int MID    = OVERSAMPLE / 2;
    localparam int SLOT_A = MID - 1;
    localparam int SLOT_B = MID;
    localparam int SLOT_C = MID + 1;
    localparam int SLOT_L = OVERSAMPLE - 1;

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic                 s0;
        logic                 s1;
        logic [DATA_BITS-1:0] shift;
        logic                 par;
        logic                 noise;
        logic                 active;
        logic [IDLE_W-1:0]    idle_cnt;
    } core_t;

    core_t q, d;
    logic bit_v, bit_nz;

    always_comb begin
        d          = q;
        frame_done = 1'b0;
        frame_data = q.shift;
        frame_fe   = 1'b0;
        frame_pe   = 1'b0;
        frame_nf   = 1'b0;
        idle_pulse = 1'b0;
        bit_v      = maj3(q.s0, q.s1, rxd);
        bit_nz     = !((q.s0 == q.s1) && (q.s1 == rxd));
        if (!rx_en) begin
            d.state    = ST_IDLE;
            d.cnt      = '0;
            d.idle_cnt = '0;
        end else if (tick) begin
            if (q.state == ST_IDLE) begin
                if (!rxd) begin
                    d.state    = ST_START;
                    d.cnt      = CNT_W'(1);
                    d.noise    = 1'b0;
                    d.par      = 1'b0;
                    d.active   = 1'b1;
                    d.idle_cnt = '0;
                end else if (q.active) begin
                    if (q.idle_cnt == IDLE_W'(IDLE_TICKS - 1)) begin
                        idle_pulse = 1'b1;
                        d.active   = 1'b0;
                        d.idle_cnt = '0;
                    end else begin
                        d.idle_cnt = q.idle_cnt + IDLE_W'(1);
                    end
                end
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == CNT_W'(SLOT_A)) d.s0 = rxd;
                if (q.cnt == CNT_W'(SLOT_B)) d.s1 = rxd;
                if (q.cnt == CNT_W'(SLOT_C)) begin
                    case (q.state)
                        ST_START: begin
                            if (bit_v) begin
                                d.state = ST_IDLE;
                                d.cnt   = '0;
                            end else begin
                                d.noise = q.noise | bit_nz;
                            end
                        end
                        ST_DATA: begin
                            d.shift = {bit_v, q.shift[DATA_BITS-1:1]};
                            d.par   = q.par ^ bit_v;
                            d.noise = q.noise | bit_nz;
                        end
                        ST_PAR: begin
                            d.par   = q.par ^ bit_v;
                            d.noise = q.noise | bit_nz;
                        end
                        ST_STOP: begin
                            frame_done = 1'b1;
                            frame_fe   = ~bit_v;
                            frame_pe   = parity_en & (q.par ^ parity_odd);
                            frame_nf   = q.noise | bit_nz;
                            d.state    = ST_IDLE;
                            d.cnt      = '0;
                        end
                        default: ;
                    endcase
                end
                if (q.cnt == CNT_W'(SLOT_L)) begin
                    case (q.state)
                        ST_START: begin
                            d.state = ST_DATA;
                            d.idx   = '0;
                        end
                        ST_DATA: begin
                            if (q.idx == IDX_W'(DATA_BITS - 1))
                                d.state = parity_en ? ST_PAR : ST_STOP;
                            else
                                d.idx = q.idx + IDX_W'(1);
                        end
                        ST_PAR:  d.state = ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 frame_fe,
    input  logic                 frame_pe,
    input  logic                 frame_nf,
    input  logic                 idle_pulse,
    input  logic                 rd_status,
    input  logic                 rd_data,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 full_o,
    output logic                 idle_o,
    output logic                 ovr_o,
    output logic                 nf_o,
    output logic                 fe_o,
    output logic                 pe_o
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 idle;
        logic                 ovr;
        logic                 nf;
        logic                 fe;
        logic                 pe;
        logic                 armed;
    } flag_t;

    flag_t q, d;
    logic  any_flag;

    always_comb begin
        d        = q;
        any_flag = q.full | q.idle | q.ovr | q.nf | q.fe | q.pe;
        if (rd_status && any_flag) d.armed = 1'b1;
        if (rd_data && q.armed) begin
            d.full  = 1'b0;
            d.idle  = 1'b0;
            d.ovr   = 1'b0;
            d.nf    = 1'b0;
            d.fe    = 1'b0;
            d.pe    = 1'b0;
            d.armed = 1'b0;
        end
        if (idle_pulse) d.idle = 1'b1;
        if (frame_done) begin
            if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = frame_data;
                d.full = 1'b1;
                d.fe   = frame_fe;
                d.pe   = frame_pe;
                d.nf   = frame_nf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.data;
    assign full_o = q.full;
    assign idle_o = q.idle;
    assign ovr_o  = q.ovr;
    assign nf_o   = q.nf;
    assign fe_o   = q.fe;
    assign pe_o   = q.pe;
endmodule

// File: rtl/uart_rx_frz.sv
module uart_rx_frz #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8,
    parameter int IDLE_TICKS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 wait_req,
    input  logic                 wait_freeze_en,
    input  logic                 stop_req,
    input  logic                 rd_status,
    input  logic                 rd_data,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_idle,
    output logic                 rx_overrun,
    output logic                 rx_noise,
    output logic                 rx_frame_err,
    output logic                 rx_parity_err
);
    logic                 frozen_w, tick_w;
    logic                 done_w, fe_w, pe_w, nf_w, idle_w;
    logic [DATA_BITS-1:0] fdata_w;

    uart_rx_gate u_gate (
        .os_tick        (os_tick),
        .rx_en          (rx_en),
        .wait_req       (wait_req),
        .wait_freeze_en (wait_freeze_en),
        .stop_req       (stop_req),
        .frozen         (frozen_w),
        .tick_en        (tick_w)
    );

    uart_rx_core #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_BITS  (DATA_BITS),
        .IDLE_TICKS (IDLE_TICKS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (tick_w),
        .rxd        (rxd),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .frame_done (done_w),
        .frame_data (fdata_w),
        .frame_fe   (fe_w),
        .frame_pe   (pe_w),
        .frame_nf   (nf_w),
        .idle_pulse (idle_w)
    );

    uart_rx_flags #(
        .DATA_BITS (DATA_BITS)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (done_w),
        .frame_data (fdata_w),
        .frame_fe   (fe_w),
        .frame_pe   (pe_w),
        .frame_nf   (nf_w),
        .idle_pulse (idle_w),
        .rd_status  (rd_status),
        .rd_data    (rd_data),
        .data_o     (rx_data),
        .full_o     (rx_full),
        .idle_o     (rx_idle),
        .ovr_o      (rx_overrun),
        .nf_o       (rx_noise),
        .fe_o       (rx_frame_err),
        .pe_o       (rx_parity_err)
    );
endmodule

// File: rtl/uart_rx_frz_chk.sv
module uart_rx_frz_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 frozen,
    input logic                 stop_req,
    input logic                 parity_en,
    input logic                 rd_data,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 rx_overrun,
    input logic                 rx_noise,
    input logic                 rx_frame_err,
    input logic                 rx_parity_err
);
    assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_full);

    assert_overrun_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && $past(rx_overrun)) |-> $stable(rx_data));

    assert_full_drops_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_data));

    assert_parity_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_parity_err) |-> $past(parity_en));

    assert_wait_freeze_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rd_data) |=> $stable({rx_data, rx_full, rx_overrun,
                                          rx_noise, rx_frame_err, rx_parity_err}));

    assert_stop_freeze_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !rd_data) |=> $stable({rx_data, rx_full}));

    assert_disabled_no_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_full) |=> !rx_full);
endmodule

bind uart_rx_frz uart_rx_frz_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .frozen        (frozen_w),
    .stop_req      (stop_req),
    .parity_en     (parity_en),
    .rd_data       (rd_data),
    .rx_data       (rx_data),
    .rx_full       (rx_full),
    .rx_overrun    (rx_overrun),
    .rx_noise      (rx_noise),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err)
);

// File: tb/uart_rx_frz_tb.sv
module uart_rx_frz_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b1, os_tick = 1'b1, rxd = 1'b1;
    logic parity_en = 1'b0, parity_odd = 1'b0;
    logic wait_req = 1'b0, wait_freeze_en = 1'b0, stop_req = 1'b0;
    logic rd_status = 1'b0, rd_data = 1'b0;
    logic [7:0] rx_data;
    logic rx_full, rx_idle, rx_overrun, rx_noise, rx_frame_err, rx_parity_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_frz u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .parity_en(parity_en), .parity_odd(parity_odd), .wait_req(wait_req),
        .wait_freeze_en(wait_freeze_en), .stop_req(stop_req),
        .rd_status(rd_status), .rd_data(rd_data), .rx_data(rx_data),
        .rx_full(rx_full), .rx_idle(rx_idle), .rx_overrun(rx_overrun),
        .rx_noise(rx_noise), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drives one bit for 16 edges. flip_edge inverts the line on that edge.
    // frz_edge freezes before that edge (kind 1 = wait with enable, 2 = stop).
    task automatic drive_bit(input logic v, input int flip_edge, input int frz_edge, input int kind);
        for (int e = 1; e <= 16; e++) begin
            @(negedge clk);
            if (e == frz_edge) begin
                if (kind == 1) begin wait_freeze_en = 1'b1; wait_req = 1'b1; end
                else stop_req = 1'b1;
                rxd = ~v;
                for (int k = 0; k < 40; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    rxd = k[0];
                end
                wait_req = 1'b0;
                stop_req = 1'b0;
                wait_freeze_en = 1'b0;
            end
            rxd = (e == flip_edge) ? ~v : v;
            @(posedge clk);
        end
    endtask

    // Bit positions: 0 start, 1..8 data, 9 parity (if any), last stop.
    task automatic send(input logic [7:0] dv, input logic bad_par, input logic bad_stop,
                        input int nz_bit, input int nz_edge,
                        input int fz_bit, input int fz_edge, input int kind);
        logic pbit;
        int   pos;
        pbit = (^dv) ^ parity_odd ^ bad_par;
        drive_bit(1'b0, (nz_bit == 0) ? nz_edge : 0, (fz_bit == 0) ? fz_edge : 0, kind);
        for (int i = 0; i < 8; i++)
            drive_bit(dv[i], (nz_bit == i + 1) ? nz_edge : 0, (fz_bit == i + 1) ? fz_edge : 0, kind);
        pos = 9;
        if (parity_en) begin
            drive_bit(pbit, (nz_bit == 9) ? nz_edge : 0, (fz_bit == 9) ? fz_edge : 0, kind);
            pos = 10;
        end
        drive_bit(~bad_stop, (nz_bit == pos) ? nz_edge : 0, (fz_bit == pos) ? fz_edge : 0, kind);
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic plain(input logic [7:0] dv);
        send(dv, 1'b0, 1'b0, -1, 0, -1, 0, 0);
    endtask

    task automatic clear_seq();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0; rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 400000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_wait(3);
        chk("R12 reset flags", {rx_full, rx_idle, rx_overrun, rx_noise, rx_frame_err, rx_parity_err}, 0);
        chk("R12 reset data", rx_data, 0);
        @(negedge clk); rst_n = 1'b1;
        idle_wait(2);

        // R1 R6: every byte without parity
        for (int b = 0; b < 256; b++) begin
            plain(b[7:0]);
            chk("R1 data", rx_data, b);
            chk("R6 full", rx_full, 1);
            chk("R5 no parity err", {rx_noise, rx_frame_err, rx_parity_err}, 0);
            clear_seq();
            chk("R9 cleared", rx_full, 0);
        end

        // R5: every byte, even parity; odd parity on a spread of bytes
        parity_en = 1'b1;
        for (int b = 0; b < 256; b++) begin
            plain(b[7:0]);
            chk("R5 even data", rx_data, b);
            chk("R5 even ok", {rx_parity_err, rx_frame_err}, 0);
            clear_seq();
        end
        parity_odd = 1'b1;
        for (int b = 0; b < 256; b += 7) begin
            plain(b[7:0]);
            chk("R5 odd data", rx_data, b);
            chk("R5 odd ok", rx_parity_err, 0);
            clear_seq();
        end
        send(8'h5A, 1'b1, 1'b0, -1, 0, -1, 0, 0);
        chk("R5 odd mismatch", rx_parity_err, 1);
        chk("R5 data kept", rx_data, 8'h5A);
        clear_seq();
        parity_odd = 1'b0;
        send(8'h3C, 1'b1, 1'b0, -1, 0, -1, 0, 0);
        chk("R5 even mismatch", rx_parity_err, 1);
        clear_seq();
        parity_en = 1'b0;

        // R4: missing stop bit
        send(8'hC3, 1'b0, 1'b1, -1, 0, -1, 0, 0);
        chk("R4 frame err", rx_frame_err, 1);
        chk("R4 data", rx_data, 8'hC3);
        idle_wait(40);
        clear_seq();

        // R3: disagreeing sample 9 in data bit 3, then in the stop bit; sample 2 ignored
        send(8'hA5, 1'b0, 1'b0, 4, 9, -1, 0, 0);
        chk("R3 noise set", rx_noise, 1);
        chk("R3 noise data", rx_data, 8'hA5);
        clear_seq();
        send(8'h11, 1'b0, 1'b0, 9, 10, -1, 0, 0);
        chk("R3 stop noise", {rx_noise, rx_frame_err}, 2'b10);
        clear_seq();
        send(8'h96, 1'b0, 1'b0, 4, 2, -1, 0, 0);
        chk("R3 outside window", rx_noise, 0);
        chk("R3 outside data", rx_data, 8'h96);
        clear_seq();

        // R2: short low glitch is rejected
        @(negedge clk); rxd = 1'b0;
        idle_wait(4);
        rxd = 1'b1;
        idle_wait(200);
        chk("R2 false start", rx_full, 0);
        clear_seq();

        // R7: overrun keeps the first byte
        plain(8'h21);
        plain(8'h84);
        chk("R7 overrun", rx_overrun, 1);
        chk("R7 data kept", rx_data, 8'h21);
        // R9: data read without status read changes nothing
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
        chk("R9 no clear", {rx_full, rx_overrun}, 2'b11);
        clear_seq();
        chk("R9 full clear", {rx_full, rx_overrun}, 0);

        // R8: idle flag after 160 high ticks following activity
        plain(8'h7E);
        clear_seq();
        chk("R8 idle early", rx_idle, 0);
        idle_wait(170);
        chk("R8 idle set", rx_idle, 1);
        clear_seq();
        idle_wait(200);
        chk("R8 no repeat", rx_idle, 0);

        // R10: wait freeze mid data bit with garbage on the line
        send(8'hB7, 1'b0, 1'b0, -1, 0, 5, 6, 1);
        chk("R10 wait resume", rx_data, 8'hB7);
        chk("R10 wait clean", {rx_full, rx_noise, rx_frame_err}, 3'b100);
        clear_seq();
        // R10: wait without enable runs normally
        @(negedge clk); wait_req = 1'b1;
        plain(8'h4D);
        chk("R10 wait no freeze", rx_data, 8'h4D);
        chk("R10 wait no freeze full", rx_full, 1);
        wait_req = 1'b0;
        clear_seq();

        // R11: stop freeze in the start bit and in the stop bit
        send(8'hE2, 1'b0, 1'b0, -1, 0, 0, 9, 2);
        chk("R11 stop resume start", rx_data, 8'hE2);
        clear_seq();
        send(8'h19, 1'b0, 1'b0, -1, 0, 9, 10, 2);
        chk("R11 stop resume stop", {rx_data, rx_full, rx_frame_err}, {8'h19, 2'b10});
        clear_seq();

        // R13: disabled receiver ignores a frame
        @(negedge clk); rx_en = 1'b0;
        plain(8'h66);
        chk("R13 ignored", rx_full, 0);
        @(negedge clk); rx_en = 1'b1;
        idle_wait(5);

        // R12: reset during stop freeze with a byte held and a partial frame
        plain(8'hF0);
        drive_bit(1'b0, 0, 0, 0);
        drive_bit(1'b1, 0, 0, 0);
        @(negedge clk); stop_req = 1'b1; rxd = 1'b1;
        idle_wait(5);
        rst_n = 1'b0;
        idle_wait(2);
        chk("R12 freeze reset", {rx_data, rx_full, rx_overrun, rx_idle}, 0);
        rst_n = 1'b1;
        idle_wait(3);
        stop_req = 1'b0;
        idle_wait(5);
        plain(8'h0F);
        chk("R12 after reset", {rx_data, rx_full, rx_frame_err}, {8'h0F, 2'b10});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule